// File: doc/BRIEF.md
# Flow-Through Burst SRAM With Zero Turnaround

This block is a synchronous single-port memory of 36-bit words, split into four 9-bit lanes (eight data bits plus one parity bit each). A read or write command may be issued on every clock edge, with no idle cycle needed when the bus changes direction. Every command, address and byte-select input is registered on the rising clock edge. Read data appears from the array in the cycle right after the command edge, with no output register (flow-through). Write data is taken one edge after its command and is committed to the array on that edge.

A short burst can follow a loaded command. While the advance/load input is high, the previous operation type carries on and a two-bit count steps the two lowest address bits. The step is either added to the start address (linear order) or XORed with it (interleaved order). A clock-enable input can freeze the whole pipeline. The external tristate pad is modelled as separate `din`, `dout` and `drive_en` signals.

The control pipeline is a three-state machine held in a phase register. The states are IDLE (deselected or reset), READ (the cycle after a read command edge) and WRITE (the data phase of a write). It has five transitions:
- load-read enters READ.
- load-write enters WRITE.
- deselect enters IDLE on a load while unselected.
- continue keeps the current state on an advance.
- hold keeps every register while clock enable is low.

Top module: `fts_sram`

## Requirements
- R1: While `rst_n` is low, the phase is IDLE and `drive_en` is 0.
- R2: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at a load edge (`adv_ld`=0). A load edge while unselected gives an IDLE phase: `drive_en` is 0 and no write happens.
- R3: A write command (`we_n`=0) registered at edge k takes `din` at edge k+1 and commits it to the array at edge k+1.
- R4: Bit `lane_we_n[i]`=0 writes bits [9i+8:9i] of the word. Lanes whose bit is 1 keep their old contents. The select bits are registered with the command edge.
- R5: After a read command edge, `dout` equals the array word at the registered address in that same cycle (flow-through).
- R6: `drive_en` is high only in a READ phase with `oe_n`=0, and it follows `oe_n` combinationally within the cycle.
- R7: During the data phase of a write, `drive_en` is 0 whatever the value of `oe_n`.
- R8: Read and write commands may alternate on every edge. A read issued right after a write to the same address returns the newly written data.
- R9: An edge with `clk_en`=0 is ignored. Phase, address, burst count and array are unchanged, so `dout` and `drive_en` hold.
- R10: With `adv_ld`=1 and linear order (`lin_mode`=1 at the load), the effective address low bits are (start + count) mod 4. The upper bits are unchanged.
- R11: With interleaved order (`lin_mode`=0 at the load), the effective address low bits are start XOR count.
- R12: An advance edge (`adv_ld`=1) that follows a deselect stays IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock qualifier; low ignores the edge |
| addr | input | ADDR_W | Word address sampled on load edges |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 = write command, 1 = read command |
| lane_we_n | input | LANES | Active-low per-lane write selects |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, taken in the data phase |
| dout | output | LANES*LANE_W | Read data, valid in READ phase |
| drive_en | output | 1 | Bus drive indication |

## Verification
On every cycle the assertions check the following. Output drive stays off in write data phases and whenever `oe_n` is high. A deselecting load is followed by no drive. A frozen edge keeps the phase and address. Each linear advance steps the low address bits by one, and an interleaved advance keeps the upper address bits. Only the bench scenarios can show data correctness. That covers byte-lane merging, the one-cycle-late commit of write data, read-after-write across direction changes, the interleaved XOR sequence and the absence of a commit when the data-phase edge is frozen. The bench checks these against its own model of the array.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              lin_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              lin_q
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b1;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= '0;
            lin_q  <= lin_in;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (lin_q) low_bits = base_q[CNT_W-1:0] + cnt_q;
        else       low_bits = base_q[CNT_W-1:0] ^ cnt_q;
    end

    assign eff_addr = {base_q[ADDR_W-1:CNT_W], low_bits};
endmodule

// File: rtl/fts_lane_mem.sv
module fts_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_wr[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             adv_ld,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             oe_n,
    output phase_e           phase_q,
    output logic             load,
    output logic             advance,
    output logic [LANES-1:0] lane_wr,
    output logic             drive_en
);
    phase_e           phase_d;
    logic [LANES-1:0] sel_q;
    logic             selected;
    logic             commit;

    assign selected = !cs1_n && cs2 && !cs3_n;
    assign load     = clk_en && !adv_ld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sel_q   <= '1;
        end else if (clk_en) begin
            phase_q <= phase_d;
            sel_q   <= lane_we_n;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE, PH_READ, PH_WRITE: begin
                if (!adv_ld) begin
                    if (!selected)  phase_d = PH_IDLE;
                    else if (we_n)  phase_d = PH_READ;
                    else            phase_d = PH_WRITE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        advance  = 1'b0;
        commit   = 1'b0;
        drive_en = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
            end
            PH_READ: begin
                advance  = clk_en && adv_ld;
                drive_en = !oe_n;
            end
            PH_WRITE: begin
                advance = clk_en && adv_ld;
                commit  = clk_en;
            end
            default: begin
            end
        endcase
    end

    assign lane_wr = {LANES{commit}} & ~sel_q;
endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    adv_ld,
    input  logic                    lin_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    drive_en
);
    localparam int WORD_W = LANES * LANE_W;

    phase_e             phase_q;
    logic               load;
    logic               advance;
    logic [LANES-1:0]   lane_wr;
    logic [ADDR_W-1:0]  eff_addr;
    logic               burst_lin;
    logic [WORD_W-1:0]  rd_word;

    fts_ctrl #(.LANES(LANES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .phase_q(phase_q),
        .load(load), .advance(advance), .lane_wr(lane_wr),
        .drive_en(drive_en)
    );

    fts_burst_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .base_in(addr), .lin_in(lin_mode), .eff_addr(eff_addr),
        .lin_q(burst_lin)
    );

    fts_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
        .clk(clk), .lane_wr(lane_wr), .addr(eff_addr), .wdata(din),
        .rdata(rd_word)
    );

    assign dout = (phase_q == PH_READ) ? rd_word : '0;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              adv_ld,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              oe_n,
    input logic              drive_en,
    input phase_e            phase_q,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              burst_lin
);
    always @(posedge clk) begin
        if (!rst_n) p_reset_quiet_r1: assert (!drive_en && phase_q == PH_IDLE);
    end

    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && (cs1_n || !cs2 || cs3_n)) |=> (phase_q == PH_IDLE && !drive_en));

    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);

    p_no_drive_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WRITE) |-> !drive_en);

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(phase_q) && $stable(eff_addr)));

    p_linear_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && phase_q != PH_IDLE && burst_lin)
        |=> (eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1));

    p_upper_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && phase_q != PH_IDLE)
        |=> (eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

    p_idle_stays_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE));
endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .oe_n(oe_n),
    .drive_en(drive_en), .phase_q(phase_q), .eff_addr(eff_addr),
    .burst_lin(burst_lin)
);

// File: tb/fts_sram_tb.sv
module fts_sram_tb_top;
    localparam int CLK_T = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          adv_ld = 1'b0;
    logic          lin_mode = 1'b1;
    logic          oe_n = 1'b0;
    logic [35:0]   din = '0;
    logic [35:0]   dout;
    logic          drive_en;

    int n_chk = 0;
    int n_fail = 0;

    // bench reference model: phase 0 idle, 1 read, 2 write
    int            m_ph = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_lin = 1'b1;
    logic [3:0]    m_sel = 4'hF;
    logic [35:0]   ref_mem [DEPTH];
    string         ctx = "";

    always #(CLK_T/2) clk = ~clk;

    fts_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n),
        .lane_we_n(lane_we_n), .adv_ld(adv_ld), .lin_mode(lin_mode),
        .oe_n(oe_n), .din(din), .dout(dout), .drive_en(drive_en)
    );

    function automatic logic [AW-1:0] m_eff();
        logic [1:0] lo;
        lo = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [35:0] w;
        if (m_ph == 2) begin
            w = ref_mem[m_eff()];
            for (int i = 0; i < 4; i++)
                if (!m_sel[i]) w[i*9 +: 9] = din[i*9 +: 9];
            ref_mem[m_eff()] = w;
        end
        if (!adv_ld) begin
            m_ph   = (!cs1_n && cs2 && !cs3_n) ? (we_n ? 1 : 2) : 0;
            m_base = addr;
            m_cnt  = '0;
            m_lin  = lin_mode;
        end else if (m_ph != 0) begin
            m_cnt = m_cnt + 2'd1;
        end
        m_sel = lane_we_n;
    endtask

    task automatic check_out(input logic ce);
        string tg;
        logic  exp_drv;
        exp_drv = (m_ph == 1) && !oe_n;
        if (ctx != "")      tg = ctx;
        else if (!ce)       tg = "R9";
        else if (m_ph == 2) tg = "R7";
        else if (m_ph == 0) tg = "R2";
        else                tg = "R6";
        check(drive_en == exp_drv, tg, {35'd0, drive_en}, {35'd0, exp_drv});
        if (m_ph == 1) begin
            if (ctx != "")          tg = ctx;
            else if (!ce)           tg = "R9";
            else if (m_cnt != 2'd0) tg = m_lin ? "R10" : "R11";
            else                    tg = "R5";
            check(dout === ref_mem[m_eff()], tg, dout, ref_mem[m_eff()]);
        end
    endtask

    task automatic cyc(input logic ce, input logic adv, input logic sel, input logic wn,
                       input logic [3:0] ben, input logic lin, input logic oen,
                       input logic [AW-1:0] a);
        @(negedge clk);
        clk_en = ce; adv_ld = adv; we_n = wn; lane_we_n = ben;
        lin_mode = lin; oe_n = oen; addr = a; din = {$urandom, $urandom};
        cs1_n = !sel; cs2 = sel; cs3_n = !sel;
        @(posedge clk);
        if (ce) model_step();
        #2;
        check_out(ce);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7531));
        repeat (3) @(posedge clk);
        #2;
        check(drive_en == 1'b0, "R1", {35'd0, drive_en}, 36'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // fill whole array so every read has a known value
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 0, 4'h0, 1, 0, AW'(i));
        cyc(1, 0, 0, 1, 4'hF, 1, 0, '0);

        // R3: write then read in the cycle after the data phase
        ctx = "R3";
        cyc(1, 0, 1, 0, 4'h0, 1, 0, AW'(9));
        cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(9));
        // R4: partial lane write, lanes 0 and 2 selected
        ctx = "R4";
        cyc(1, 0, 1, 0, 4'b1010, 1, 0, AW'(5));
        cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(5));
        // R8: alternating write/read on the same addresses
        ctx = "R8";
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0, 1, 0, 4'h0, 1, 0, AW'(20 + i));
            cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(20 + i));
        end
        // R2: deselected write must not touch memory
        ctx = "R2";
        cyc(1, 0, 0, 0, 4'h0, 1, 0, AW'(9));
        cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(9));
        // R12: advance after deselect stays idle
        ctx = "R12";
        cyc(1, 0, 0, 1, 4'hF, 1, 0, AW'(3));
        cyc(1, 1, 1, 1, 4'hF, 1, 0, AW'(3));
        cyc(1, 1, 1, 0, 4'h0, 1, 0, AW'(3));
        // R10: linear burst from 5 -> 5,6,7,4
        ctx = "";
        cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(5));
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 4'hF, 1, 0, AW'(0));
        // R11: interleaved burst from 5 -> 5,4,7,6
        cyc(1, 0, 1, 1, 4'hF, 0, 0, AW'(5));
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 4'hF, 0, 0, AW'(0));
        // R9: freeze during a write data phase, then finish it
        ctx = "R9";
        cyc(1, 0, 1, 0, 4'h0, 1, 0, AW'(30));
        cyc(0, 0, 1, 1, 4'hF, 1, 0, AW'(31));
        cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(30));
        cyc(0, 0, 0, 0, 4'h0, 1, 0, AW'(2));
        // R6: oe_n raised mid-cycle drops drive combinationally
        ctx = "R6";
        cyc(1, 0, 1, 1, 4'hF, 1, 0, AW'(30));
        oe_n = 1'b1;
        #1;
        check(drive_en == 1'b0, "R6", {35'd0, drive_en}, 36'd0);
        ctx = "";

        for (int i = 0; i < 800; i++) begin
            logic ce, adv, sel;
            ce  = ($urandom % 100) < 85;
            adv = ($urandom % 100) < 30;
            sel = ($urandom % 100) < 85;
            cyc(ce, adv, sel, 1'($urandom), 4'($urandom), 1'($urandom),
                ($urandom % 100) < 20, AW'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule